// File: doc/BRIEF.md
# Magnetometer Result Holding Bank

This block holds the latest three-axis measurement for a bus-readable magnetometer register file. The measurement sequencer hands it one complete result set, three signed 16-bit axis values, with a single-cycle strobe. The block stores each value as a high byte and a low byte. The bus slave reports each byte it returns to the host with a read strobe that carries the register location. From these inputs the block drives the six stored bytes and a status byte that reports whether fresh data is present and whether the bank is frozen.

Once the host has fetched some of the six bytes but not all of them, the bank freezes. No further result set is written into it, so the host never mixes bytes from two different measurements. Any set that arrives during the freeze is discarded. Three things release the freeze: reading every byte, a change of operating mode, or a change of measurement configuration. The ready flag drops whenever a set is written and comes back only after a guaranteed minimum number of clock cycles. Software that polls the flag therefore always sees the low pulse.

Top module: `mag_result_bank`

## Requirements
- R1: After reset all six bank bytes read 0x00, and status bits 0 (ready) and 1 (frozen) are clear.
- R2: When a result strobe arrives while the bank is not frozen, the six bytes in `bank_o` take the new values one cycle later. Byte k of `bank_o` (bits 8k+7:8k) is register location 3+k, and the locations in order are X high, X low, Z high, Z low, Y high, Y low.
- R3: A read strobe at a location from 3 to 8 marks that byte as fetched. Once at least one byte but not all six are marked, status bit 1 reads 1 from the next cycle on.
- R4: A result strobe that arrives while status bit 1 is set is discarded. The bank bytes and the ready bit stay unchanged.
- R5: When the last unmarked byte is read, status bit 1 clears on the next cycle, and the next result strobe is accepted.
- R6: A mode-change or configuration-change pulse clears status bit 1 on the next cycle and forgets the bytes already fetched. A result strobe that follows the pulse is accepted.
- R7: A read strobe at any location outside 3 to 8 has no effect on status bit 1.
- R8: The cycle after a set is accepted, status bit 0 is low. It stays low for exactly RDY_LOW_CYC cycles and then rises. Reads do not clear it.
- R9: Status bit 2 follows the regulator-enabled input, and status bits 7 to 3 read 0.
- R10: Reading the same location several times marks only that one byte, so repeated reads of one byte keep the bank frozen.
- R11: Accepting a new set while the ready bit is still held low restarts the full RDY_LOW_CYC low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld_i | input | 1 | One-cycle strobe: a complete result set is offered |
| res_x_i | input | AXIS_W | X result, two's complement |
| res_y_i | input | AXIS_W | Y result, two's complement |
| res_z_i | input | AXIS_W | Z result, two's complement |
| rd_stb_i | input | 1 | One-cycle strobe: the bus slave returned a byte |
| rd_loc_i | input | LOC_W | Register location of that read |
| mode_chg_i | input | 1 | Pulse: the operating mode was rewritten |
| cfg_chg_i | input | 1 | Pulse: the measurement configuration was rewritten |
| reg_on_i | input | 1 | Internal regulator enabled |
| bank_o | output | 3*AXIS_W | Stored bytes, byte k = location 3+k |
| status_o | output | 8 | {00000, regulator on, frozen, ready} |

## Verification
The assertions take for granted that every input pulse lasts one cycle. They also assume a read strobe never coincides with a result strobe or with a change pulse, because the block gives the result or the release priority over a read in the same cycle. The stimulus meets these assumptions by driving each event in its own cycle. Every subset of fetched bytes is swept, so that both the frozen state and its release are reached from all 62 partial patterns.

// File: rtl/magbank_pkg.sv
package magbank_pkg;
  localparam int unsigned AXES = 3;

  typedef struct packed {
    logic [4:0] zero;
    logic       reg_on;
    logic       frozen;
    logic       ready;
  } status_t;
endpackage

// File: rtl/magbank_store.sv
module magbank_store #(
  parameter int unsigned AXIS_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   load,
  input  logic [magbank_pkg::AXES*AXIS_W-1:0]    slots,
  output logic [magbank_pkg::AXES*AXIS_W-1:0]    bank
);
  localparam int unsigned BPA = AXIS_W / 8;

  logic [magbank_pkg::AXES*AXIS_W-1:0] packed_d;
  logic [magbank_pkg::AXES*AXIS_W-1:0] bank_d, bank_q;

  for (genvar s = 0; s < magbank_pkg::AXES; s++) begin : g_slot
    for (genvar b = 0; b < BPA; b++) begin : g_byte
      assign packed_d[8*(s*BPA+b) +: 8] = slots[s*AXIS_W + AXIS_W-1-8*b -: 8];
    end
  end

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = packed_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank = bank_q;
endmodule

// File: rtl/magbank_track.sv
module magbank_track #(
  parameter int unsigned NBYTE = 6,
  parameter int unsigned LOC_W = 4,
  parameter int unsigned BASE  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [LOC_W-1:0] rd_loc,
  input  logic             release_i,
  input  logic             accept,
  output logic             frozen
);
  logic [NBYTE-1:0] hit;
  logic [NBYTE-1:0] mask_d, mask_q, merged;

  always_comb begin
    for (int i = 0; i < NBYTE; i++)
      hit[i] = rd_stb && (rd_loc == LOC_W'(BASE + i));
  end

  assign merged = mask_q | hit;

  always_comb begin
    mask_d = mask_q;
    if (release_i || accept) mask_d = '0;
    else if (|hit)           mask_d = (&merged) ? '0 : merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign frozen = |mask_q;
endmodule

// File: rtl/magbank_rdy.sv
module magbank_rdy #(
  parameter int unsigned LOW_CYC = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic ready
);
  localparam int unsigned CW = $clog2(LOW_CYC + 1);

  logic [CW-1:0] cnt_d, cnt_q;
  logic          rdy_d, rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (accept) begin
      cnt_d = CW'(LOW_CYC);
      rdy_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/mag_result_bank.sv
module mag_result_bank #(
  parameter int unsigned AXIS_W      = 16,
  parameter int unsigned LOC_W       = 4,
  parameter int unsigned BASE_LOC    = 3,
  parameter int unsigned RDY_LOW_CYC = 625
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   res_vld_i,
  input  logic [AXIS_W-1:0]      res_x_i,
  input  logic [AXIS_W-1:0]      res_y_i,
  input  logic [AXIS_W-1:0]      res_z_i,
  input  logic                   rd_stb_i,
  input  logic [LOC_W-1:0]       rd_loc_i,
  input  logic                   mode_chg_i,
  input  logic                   cfg_chg_i,
  input  logic                   reg_on_i,
  output logic [3*AXIS_W-1:0]    bank_o,
  output logic [7:0]             status_o
);
  import magbank_pkg::*;

  localparam int unsigned NBYTE = AXES * AXIS_W / 8;

  logic    frozen, ready, accept;
  status_t st;

  assign accept = res_vld_i && !frozen;

  magbank_store #(.AXIS_W(AXIS_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .slots ({res_y_i, res_z_i, res_x_i}),
    .bank  (bank_o)
  );

  magbank_track #(.NBYTE(NBYTE), .LOC_W(LOC_W), .BASE(BASE_LOC)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb_i),
    .rd_loc    (rd_loc_i),
    .release_i (mode_chg_i || cfg_chg_i),
    .accept    (accept),
    .frozen    (frozen)
  );

  magbank_rdy #(.LOW_CYC(RDY_LOW_CYC)) u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .ready  (ready)
  );

  always_comb begin
    st        = '0;
    st.reg_on = reg_on_i;
    st.frozen = frozen;
    st.ready  = ready;
  end

  assign status_o = st;
endmodule

// File: rtl/mag_result_bank_chk.sv
module mag_result_bank_chk #(
  parameter int unsigned AXIS_W      = 16,
  parameter int unsigned RDY_LOW_CYC = 625
) (
  input logic                clk,
  input logic                rst_n,
  input logic                res_vld_i,
  input logic [AXIS_W-1:0]   res_x_i,
  input logic                mode_chg_i,
  input logic                cfg_chg_i,
  input logic [3*AXIS_W-1:0] bank_o,
  input logic [7:0]          status_o
);
  localparam int unsigned LW = $clog2(RDY_LOW_CYC + 2);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              low_cnt <= '0;
    else if (status_o[0])                    low_cnt <= '0;
    else if (low_cnt != LW'(RDY_LOW_CYC + 1)) low_cnt <= low_cnt + 1'b1;
  end

  // R4: frozen bank ignores an offered set
  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[1] && res_vld_i) |=> $stable(bank_o));

  // R6: change pulses release the freeze
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg_i || cfg_chg_i) |=> !status_o[1]);

  // R2: unfrozen set lands, X high byte at byte 0
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && !status_o[1]) |=> (bank_o[7:0] == $past(res_x_i[AXIS_W-1 -: 8])));

  // R8: ready drops after accept and honours the minimum low time
  assert_rdy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && !status_o[1]) |=> !status_o[0]);

  assert_rdy_min_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> (low_cnt >= LW'(RDY_LOW_CYC)));

  // R2/R4: bank changes only after an offered set
  assert_bank_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_o) |-> $past(res_vld_i));
endmodule

bind mag_result_bank mag_result_bank_chk #(
  .AXIS_W(AXIS_W), .RDY_LOW_CYC(RDY_LOW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .res_vld_i(res_vld_i), .res_x_i(res_x_i),
  .mode_chg_i(mode_chg_i), .cfg_chg_i(cfg_chg_i),
  .bank_o(bank_o), .status_o(status_o)
);

// File: tb/sim_mag_result_bank.sv
module sim_mag_result_bank;
  localparam int L = 625;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_vld_i = 1'b0;
  logic [15:0] res_x_i = '0, res_y_i = '0, res_z_i = '0;
  logic        rd_stb_i = 1'b0;
  logic [3:0]  rd_loc_i = '0;
  logic        mode_chg_i = 1'b0, cfg_chg_i = 1'b0, reg_on_i = 1'b0;
  logic [47:0] bank_o;
  logic [7:0]  status_o;

  int tests = 0, fails = 0, seed = 0;
  logic [47:0] exp_bank = '0;

  always #4 clk = ~clk;

  mag_result_bank #(.RDY_LOW_CYC(L)) u0 (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] axis_val(input int s, input int a);
    return 16'((((s * 131 + a * 977) % 4096) - 2048));
  endfunction

  function automatic logic [47:0] mk_bank(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    return {y[7:0], y[15:8], z[7:0], z[15:8], x[7:0], x[15:8]};
  endfunction

  task automatic offer(output logic [47:0] img);
    seed++;
    res_x_i = axis_val(seed, 0);
    res_y_i = axis_val(seed, 1);
    res_z_i = axis_val(seed, 2);
    img = mk_bank(res_x_i, res_y_i, res_z_i);
    res_vld_i = 1'b1;
    tick();
    res_vld_i = 1'b0;
  endtask

  task automatic rd(input int loc);
    rd_loc_i = 4'(loc);
    rd_stb_i = 1'b1;
    tick();
    rd_stb_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] img;
    logic [7:0]  rdy_before;
    bit          all_low;
    @(negedge clk);
    chk(bank_o == 48'h0 && status_o == 8'h00, "R1 reset", {bank_o, status_o}, 64'h0);
    rst_n = 1'b1;
    tick();
    chk(bank_o == 48'h0 && status_o == 8'h00, "R1 after release", {bank_o, status_o}, 64'h0);

    // R9: regulator bit and zero upper bits
    reg_on_i = 1'b1;
    #1;
    chk(status_o == 8'h04, "R9 regulator on", status_o, 8'h04);
    reg_on_i = 1'b0;
    #1;
    chk(status_o == 8'h00, "R9 regulator off", status_o, 8'h00);

    // R2 / R8: first accept and exact low window
    offer(img);
    exp_bank = img;
    chk(bank_o == exp_bank, "R2 first set", bank_o, exp_bank);
    all_low = 1'b1;
    for (int i = 0; i < L; i++) begin
      if (status_o[0]) all_low = 1'b0;
      tick();
    end
    chk(all_low, "R8 low for window", 0, 0);
    chk(status_o[0] == 1'b1, "R8 rises after window", status_o, 8'h01);
    rd(3);
    chk(status_o[0] == 1'b1, "R8 read keeps ready", status_o, 8'h03);
    rd(4); rd(5); rd(6); rd(7); rd(8);
    chk(status_o[1] == 1'b0, "R5 full read unfreezes", status_o, 8'h01);

    // R11: restart of the low window
    offer(img);
    exp_bank = img;
    repeat (3) tick();
    offer(img);
    exp_bank = img;
    all_low = 1'b1;
    for (int i = 0; i < L; i++) begin
      if (status_o[0]) all_low = 1'b0;
      tick();
    end
    chk(all_low && status_o[0], "R11 window restarted", status_o, 8'h01);

    // R7: locations outside 3..8
    for (int loc = 0; loc < 16; loc++) begin
      if (loc < 3 || loc > 8) begin
        rd(loc);
        chk(status_o[1] == 1'b0, "R7 outside read", status_o, 8'h01);
      end
    end

    // R10: same byte read repeatedly
    for (int i = 0; i < 6; i++) rd(4);
    chk(status_o[1] == 1'b1, "R10 repeated read stays frozen", status_o, 8'h03);
    mode_chg_i = 1'b1; tick(); mode_chg_i = 1'b0;

    // sweep of every partial subset
    for (int m = 1; m < 63; m++) begin
      for (int k = 0; k < 6; k++) if (m[k]) rd(3 + k);
      chk(status_o[1] == 1'b1, "R3 partial read freezes", status_o, 8'h02);
      rdy_before = status_o;
      offer(img);
      chk(bank_o == exp_bank && status_o[0] == rdy_before[0], "R4 frozen drops set",
          bank_o, exp_bank);
      for (int k = 0; k < 6; k++) if (!m[k]) rd(3 + k);
      chk(status_o[1] == 1'b0, "R5 remaining read unfreezes", status_o, 8'h00);
      offer(img);
      exp_bank = img;
      chk(bank_o == exp_bank, "R2 accepted after unfreeze", bank_o, exp_bank);
    end

    // R6: release by mode or configuration change
    for (int src = 0; src < 2; src++) begin
      for (int m = 1; m < 63; m += 7) begin
        for (int k = 0; k < 6; k++) if (m[k]) rd(3 + k);
        if (src == 0) mode_chg_i = 1'b1; else cfg_chg_i = 1'b1;
        tick();
        mode_chg_i = 1'b0; cfg_chg_i = 1'b0;
        chk(status_o[1] == 1'b0, "R6 change releases", status_o, 8'h00);
        offer(img);
        exp_bank = img;
        chk(bank_o == exp_bank, "R6 set accepted after release", bank_o, exp_bank);
        rd(3);
        chk(status_o[1] == 1'b1, "R6 fetched bytes forgotten", status_o, 8'h02);
        rd(4); rd(5); rd(6); rd(7); rd(8);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule